// File: doc/BRIEF.md
# 64-bit Compare Timer

A free-running 64-bit up-counter paired with a 64-bit comparator, reached over a small 32-bit register bus. Once started, the counter advances by one on every clock. When the comparator is armed and the count reaches or passes the programmed target, an event flag is latched, and the flag can drive a level interrupt output. Software acknowledges an event by writing a one to the flag bit.

For periodic events without any software reload, an auto-increment mode adds a programmed step to the comparator at each match. The next event then lands exactly one step later, and the counter itself never stops or restarts. Each 64-bit quantity is split into a lower and an upper 32-bit word. The count is held in one register and updated in one step, so a carry out of the lower word shows in the upper word in the same cycle. A software reader that samples upper, lower, then upper again therefore sees a consistent value whenever the two upper reads match.

Top module: `gtimer64`

## Requirements
- R1: After reset, every register (offsets 0x0, 0x4, 0x8, 0xC, 0x10, 0x14, 0x18) reads zero and `irq` is low.
- R2: While control bit 0 (run) is set, the count rises by exactly one per clock. While it is clear, the count holds its value.
- R3: Writes to the count words (0x0 lower, 0x4 upper) take effect only while run is clear. While the timer runs they are ignored and counting goes on undisturbed.
- R4: The count is a single 64-bit value. A carry from the lower word reaches the upper word on the same clock, and the count wraps from all ones to zero.
- R5: A match occurs when run and control bit 1 (compare enable) are both set and the count, as an unsigned 64-bit number, is greater than or equal to the comparator (0x10 lower, 0x14 upper). The event flag (bit 0 at 0xC) is set on the clock edge that follows the first cycle of the match. A count still below the target leaves the flag clear.
- R6: With control bit 3 (auto-increment) set, the clock edge that records a match also adds the step register (0x18, zero-extended) to the comparator.
- R7: A write to 0xC with bit 0 set clears the event flag. A write with bit 0 clear leaves the flag unchanged.
- R8: `irq` equals the event flag ANDed with control bit 2 (interrupt enable). Clearing bit 2 masks `irq` but keeps the flag.
- R9: The control register at 0x8 reads back its bits 3:0, the step reads back at 0x18, and any unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_wdata | input | WORD_W (32) | Write data |
| bus_rdata | output | WORD_W (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt: event flag masked by the interrupt enable |

## Verification
The compare path is driven from a table of start counts and targets. Some targets are still ahead after the run, so no event may occur. One target is met on exactly the last counted cycle, which separates "greater or equal" from "greater". Other cases cross the 32-bit word boundary, where only the upper word decides the outcome, and the 64-bit wrap, where a truncated or word-wise comparison would fail. Rows with the comparator or the interrupt enable cleared separate the flag from the interrupt line. Directed sequences then step a periodic run one cycle at a time around each match, to pin down when the comparator advances. They also attempt count writes while running and while stopped, and write the status register with bit 0 clear and then set.

// File: rtl/gtimer64_pkg.sv
package gtimer64_pkg;

  // Byte offsets of the software-visible registers
  localparam int OFS_CNT_LO = 'h00;
  localparam int OFS_CNT_HI = 'h04;
  localparam int OFS_CTRL   = 'h08;
  localparam int OFS_STAT   = 'h0C;
  localparam int OFS_CMP_LO = 'h10;
  localparam int OFS_CMP_HI = 'h14;
  localparam int OFS_STEP   = 'h18;

  localparam int CTRL_W = 4;

  // Control word, bit 3 down to bit 0
  typedef struct packed {
    logic auto_inc;   // bit 3
    logic irq_en;     // bit 2
    logic match_en;   // bit 1
    logic run;        // bit 0
  } ctrl_t;

endpackage

// File: rtl/gtimer64_count.sv
module gtimer64_count #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 2,
  localparam int CNT_W  = WORD_W * N_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [N_WORDS-1:0] load,
  input  logic [WORD_W-1:0]  wdata,
  output logic [CNT_W-1:0]   count
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] advanced;
  logic [CNT_W-1:0] count_d;

  assign advanced = run ? bump(count) : count;

  // Per-word load path; a word not loaded follows the advanced value
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign count_d[w*WORD_W +: WORD_W] = load[w] ? wdata : advanced[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && load == '0) |=> (count == $past(count) + CNT_W'(1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && load == '0) |=> $stable(count));

endmodule

// File: rtl/gtimer64_match.sv
module gtimer64_match #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 2,
  localparam int CNT_W  = WORD_W * N_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               armed,
  input  logic               auto_inc,
  input  logic [CNT_W-1:0]   count,
  input  logic [N_WORDS-1:0] cmp_load,
  input  logic               step_load,
  input  logic [WORD_W-1:0]  wdata,
  output logic [CNT_W-1:0]   cmp,
  output logic [WORD_W-1:0]  step,
  output logic               hit
);

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] t, input logic [WORD_W-1:0] s);
    return t + CNT_W'(s);
  endfunction

  logic             level;
  logic             level_q;
  logic [CNT_W-1:0] cmp_next;
  logic [CNT_W-1:0] cmp_d;

  assign level    = armed && reached(count, cmp);
  assign hit      = level && !level_q;
  assign cmp_next = (hit && auto_inc) ? advance(cmp, step) : cmp;

  // A software write to a comparator word takes precedence over the advance
  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign cmp_d[w*WORD_W +: WORD_W] = cmp_load[w] ? wdata : cmp_next[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cmp     <= '0;
      step    <= '0;
    end else begin
      level_q <= level;
      cmp     <= cmp_d;
      if (step_load) step <= wdata;
    end
  end

  // R6
  cmp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && auto_inc && cmp_load == '0) |=> (cmp == $past(cmp) + CNT_W'($past(step))));

endmodule

// File: rtl/gtimer64.sv
module gtimer64
  import gtimer64_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int N_WORDS = 2;
  localparam int CNT_W   = WORD_W * N_WORDS;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(OFS_CNT_LO);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(OFS_CNT_HI);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(OFS_CMP_LO);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(OFS_CMP_HI);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(OFS_STEP);

  ctrl_t              ctrl_q;
  logic               flag_q;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   cmp;
  logic [WORD_W-1:0]  step;
  logic               match_hit;
  logic [N_WORDS-1:0] cnt_load;
  logic [N_WORDS-1:0] cmp_load;
  logic               step_load;
  logic               ctrl_load;
  logic               clr_req;

  // Register decode; count words are frozen against writes while running
  assign cnt_load  = {bus_we && bus_addr == A_CNT_HI, bus_we && bus_addr == A_CNT_LO}
                     & {N_WORDS{!ctrl_q.run}};
  assign cmp_load  = {bus_we && bus_addr == A_CMP_HI, bus_we && bus_addr == A_CMP_LO};
  assign step_load = bus_we && bus_addr == A_STEP;
  assign ctrl_load = bus_we && bus_addr == A_CTRL;
  assign clr_req   = bus_we && bus_addr == A_STAT && bus_wdata[0];

  gtimer64_count #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ctrl_q.run),
    .load  (cnt_load),
    .wdata (bus_wdata),
    .count (count)
  );

  gtimer64_match #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (ctrl_q.run && ctrl_q.match_en),
    .auto_inc  (ctrl_q.auto_inc),
    .count     (count),
    .cmp_load  (cmp_load),
    .step_load (step_load),
    .wdata     (bus_wdata),
    .cmp       (cmp),
    .step      (step),
    .hit       (match_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_load) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (match_hit)    flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
    end
  end

  assign irq = flag_q && ctrl_q.irq_en;

  always_comb begin
    unique case (bus_addr)
      A_CNT_LO: bus_rdata = count[WORD_W-1:0];
      A_CNT_HI: bus_rdata = count[CNT_W-1:WORD_W];
      A_CTRL:   bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
      A_STAT:   bus_rdata = {{(WORD_W-1){1'b0}}, flag_q};
      A_CMP_LO: bus_rdata = cmp[WORD_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CNT_W-1:WORD_W];
      A_STEP:   bus_rdata = step;
      default:  bus_rdata = '0;
    endcase
  end

  // R5
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> flag_q);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match_hit) |=> !flag_q);

endmodule

// File: tb/gtimer64_bench.sv
module gtimer64_bench;

  localparam int CLK_NS = 10;
  localparam int W      = 32;
  localparam int AW     = 5;
  localparam int NV     = 9;

  typedef struct packed {
    logic [3:0]  ctrl;
    logic [63:0] start;
    logic [63:0] target;
    logic [15:0] cycles;
    logic        flag;
    logic [63:0] cnt;
  } vec_t;

  // ctrl 7 = run|compare|irq; expected flag is 1 when start+cycles-1 >= target
  localparam vec_t VECS [NV] = '{
    '{4'h7, 64'h0,                   64'd20,                  16'd10, 1'b0, 64'd10},
    '{4'h7, 64'h0,                   64'd20,                  16'd20, 1'b0, 64'd20},
    '{4'h7, 64'h0,                   64'd20,                  16'd21, 1'b1, 64'd21},
    '{4'h7, 64'h3_FFFF_FFFE,         64'h4_0000_0000,         16'd3,  1'b1, 64'h4_0000_0001},
    '{4'h7, 64'h4_0000_0000,         64'h3_FFFF_FFFF,         16'd1,  1'b1, 64'h4_0000_0001},
    '{4'h7, 64'h0_FFFF_FFF0,         64'h1_0000_0000,         16'd5,  1'b0, 64'h0_FFFF_FFF5},
    '{4'h7, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 16'd3,  1'b1, 64'h1},
    '{4'h5, 64'h0,                   64'd5,                   16'd10, 1'b0, 64'd10},
    '{4'h3, 64'h0,                   64'd5,                   16'd10, 1'b1, 64'd10}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          irq;

  int errors = 0;
  int checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  gtimer64 #(.WORD_W(W), .ADDR_W(AW)) u_gtimer64 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Called just after a falling edge; crosses exactly one rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd64(input logic [AW-1:0] a, output logic [63:0] d);
    logic [W-1:0] hi, lo;
    rd(a + AW'(4), hi);
    rd(a, lo);
    d = {hi, lo};
  endtask

  task automatic wr64(input logic [AW-1:0] a, input logic [63:0] d);
    wr(a, d[31:0]);
    wr(a + AW'(4), d[63:32]);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    vec_t         v;
    logic [W-1:0] d;
    logic [63:0]  q;

    wait_cyc(3);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a <= 'h18; a += 4) begin
      rd(AW'(a), d);
      check("R1", $sformatf("reg 0x%0h after reset", a), d, 0);
    end
    check("R1", "irq after reset", irq, 0);

    // Table: one-shot compare cases
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      wr(AW'('h08), 0);
      wr(AW'('h0C), 1);
      wr64(AW'('h00), v.start);
      wr64(AW'('h10), v.target);
      wr(AW'('h18), 0);
      wr(AW'('h08), {28'd0, v.ctrl});
      wait_cyc(int'(v.cycles));
      rd64(AW'('h00), q);
      check("R4", $sformatf("vec %0d count", i), q, v.cnt);
      rd(AW'('h0C), d);
      check("R5", $sformatf("vec %0d flag", i), d, {63'd0, v.flag});
      check("R8", $sformatf("vec %0d irq", i), irq, v.flag & v.ctrl[2]);
    end

    // R3 / R2: count writes while running and while stopped
    wr(AW'('h08), 0);
    wr(AW'('h0C), 1);
    wr64(AW'('h00), 64'd100);
    wr(AW'('h08), 1);
    wr(AW'('h00), 5);
    rd(AW'('h00), d);
    check("R3", "count write while running ignored", d, 101);
    wr(AW'('h08), 0);
    wait_cyc(5);
    rd(AW'('h00), d);
    check("R2", "count holds when stopped", d, 102);
    wr(AW'('h00), 7);
    rd64(AW'('h00), q);
    check("R3", "count write while stopped", q, 7);

    // R6 / R7 / R8: periodic events
    wr(AW'('h0C), 1);
    wr64(AW'('h00), 0);
    wr64(AW'('h10), 64'd10);
    wr(AW'('h18), 10);
    wr(AW'('h08), 'hF);
    wait_cyc(10);
    rd(AW'('h0C), d);
    check("R5", "flag before first period", d, 0);
    rd64(AW'('h10), q);
    check("R6", "comparator before first match", q, 10);
    wait_cyc(1);
    rd(AW'('h0C), d);
    check("R5", "flag at first period", d, 1);
    rd64(AW'('h10), q);
    check("R6", "comparator advanced once", q, 20);
    check("R8", "irq with flag and enable", irq, 1);
    wr(AW'('h0C), 0);
    rd(AW'('h0C), d);
    check("R7", "status write of zero keeps flag", d, 1);
    wr(AW'('h0C), 1);
    rd(AW'('h0C), d);
    check("R7", "status write of one clears flag", d, 0);
    check("R7", "irq drops with flag", irq, 0);
    wait_cyc(7);
    rd(AW'('h0C), d);
    check("R6", "no event before second period", d, 0);
    wait_cyc(1);
    rd(AW'('h0C), d);
    check("R6", "flag at second period", d, 1);
    rd64(AW'('h10), q);
    check("R6", "comparator advanced twice", q, 30);
    rd64(AW'('h00), q);
    check("R2", "count kept running", q, 21);
    wr(AW'('h08), 'hB);
    check("R8", "irq masked by enable", irq, 0);
    rd(AW'('h0C), d);
    check("R8", "flag kept while masked", d, 1);

    // R9: readback and unmapped offsets
    rd(AW'('h08), d);
    check("R9", "control readback", d, 'hB);
    rd(AW'('h18), d);
    check("R9", "step readback", d, 10);
    rd(AW'('h1C), d);
    check("R9", "unmapped offset", d, 0);

    summary();
  end

endmodule